// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a 16 KB direct-mapped data cache with 32-byte lines. It sits between a 32-bit load/store port on the CPU side and a DRAM controller that is reached through three clock-crossing FIFOs: a command FIFO that takes a 3-bit command code and a 31-bit DRAM address, a write-data FIFO, and a read-data FIFO. Loads and byte-masked stores that hit finish in the cycle they are presented. A miss raises a stall toward the CPU until the access can complete.

The policy is write-back with write-allocate. A miss whose victim line is dirty first sends that line to DRAM: one write command, then two 128-bit beats. A single read command then fetches the wanted line, which returns as two 128-bit halves. Once the line is filled, the pending access completes as a hit. The CPU must hold its address, data, strobes and read enable stable for as long as stall is high.

Top module: `wb_dcache`

## Requirements
- R1: The address is split as byte offset `[4:0]`, line index `[13:5]` (512 lines) and tag `[31:14]`. An access whose index matches a resident line but whose tag differs is a miss and replaces that line.
- R2: After a synchronous active-low reset, every line is invalid. While idle, `cpu_stall`, `mem_cmd_push`, `wbuf_push` and `rbuf_pop` are low. The first access to any address after reset is a miss.
- R3: Command code `3'b000` means write and `3'b001` means read. No other code is ever pushed. A command is pushed only in a cycle where `mem_cmd_full` is low.
- R4: The DRAM address of a line is its line-aligned byte address shifted right by 3, which is `{2'b00, addr[31:5], 2'b00}`. This holds for both refill and write-back commands.
- R5: A dirty victim is written back before the refill read is issued, as one write command followed by two beats. Beat 0 carries line bytes 0-15 and beat 1 carries bytes 16-31. Word w of a line occupies bits `[32w+31:32w]`. `wbuf_mask_n` is all zeros, since a 0 enables a byte. Beats are pushed only while `wbuf_full` is low.
- R6: A refill issues one read command and then holds `rbuf_pop` high until two valid beats have been taken. The first beat fills bytes 0-15 and the second fills bytes 16-31. The filled line ends up valid and clean.
- R7: A load hit returns the word selected by `addr[4:2]` on `cpu_rdata` in the same cycle, with `cpu_stall` low.
- R8: A store hit writes byte lane b (`cpu_wdata[8b+7:8b]`) only where `cpu_wstrb[b]` is 1. It keeps the other bytes of the word, marks the line dirty and keeps `cpu_stall` low.
- R9: On a miss, `cpu_stall` is high from the cycle the miss is presented until the cycle in which the access hits. A store miss allocates the line and then merges the store into it.
- R10: A miss whose victim is invalid or clean issues no write command and no write-data beats.
- R11: While `mem_cmd_full` or `wbuf_full` is high, the corresponding push stays low. The miss waits and then completes correctly once the flag drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Store data |
| cpu_wstrb | input | 4 | Per-byte store enable; nonzero means store |
| cpu_rd | input | 1 | Load request |
| cpu_stall | output | 1 | CPU must hold its request and wait |
| cpu_rdata | output | 32 | Load data |
| mem_cmd_full | input | 1 | Command FIFO cannot accept |
| mem_cmd_push | output | 1 | Push a command |
| mem_cmd_code | output | 3 | 000 write, 001 read |
| mem_cmd_addr | output | 31 | DRAM address (64-bit units) |
| wbuf_full | input | 1 | Write-data FIFO cannot accept |
| wbuf_push | output | 1 | Push a write beat |
| wbuf_data | output | 128 | Write beat data |
| wbuf_mask_n | output | 16 | Active-low byte mask |
| rbuf_valid | input | 1 | Read-data FIFO holds a beat |
| rbuf_data | input | 128 | Read beat data |
| rbuf_pop | output | 1 | Take a beat from the read-data FIFO |

## Verification
Hit results appear in the same cycle as the request, so each check drives the request just after a falling edge and samples `cpu_stall` and `cpu_rdata` 8 ns later, shortly before the rising edge that would commit a store. For a miss, the bench repeats that late-cycle sample once per cycle until stall drops. It counts the stalled cycles and reads the data only in the first cycle with stall low; that is the cycle after the last refill beat has been registered. Pushes into the DRAM model are taken at the same late point of each cycle, so every command and beat is counted against the full flags that were in force at the edge that accepts it. Store effects are checked on a later load rather than in the cycle of the store.

// File: rtl/dcache_pkg.sv
`timescale 1ns/1ps
// dcache_pkg: shared controller state encoding and DRAM command codes.
// Assumes a 3-bit command field as seen by the DRAM command FIFO.
package dcache_pkg;
    localparam int CMD_W = 3;
    localparam logic [CMD_W-1:0] CMD_WRITE = 3'b000;
    localparam logic [CMD_W-1:0] CMD_READ  = 3'b001;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WB_CMD,
        ST_WB_DATA,
        ST_RD_CMD,
        ST_RD_DATA
    } dc_state_e;
endpackage

// File: rtl/dcache_tag_store.sv
`timescale 1ns/1ps
// dcache_tag_store: per-line tag, valid and dirty state.
// The read is combinational at the given index. A fill loads a new tag,
// sets valid and clears dirty. mark_dirty sets the dirty bit of the line.
// Assumes fill_we and mark_dirty are never high in the same cycle.
module dcache_tag_store #(
    parameter int NUM_LINES = 512,
    parameter int IDX_W     = 9,
    parameter int TAG_W     = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag_out,
    output logic             valid_out,
    output logic             dirty_out,
    input  logic             fill_we,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             mark_dirty
);
    logic [TAG_W-1:0]     tag_q [NUM_LINES];
    logic [NUM_LINES-1:0] valid_q;
    logic [NUM_LINES-1:0] dirty_q;

    // Lookup of the addressed line.
    always_comb begin
        tag_out   = tag_q[idx];
        valid_out = valid_q[idx];
        dirty_out = dirty_q[idx];
    end

    // Tag capture on fill; no reset is needed since valid guards the tags.
    always_ff @(posedge clk) begin
        if (fill_we) tag_q[idx] <= fill_tag;
    end

    // Valid and dirty bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (fill_we) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    assert_dirty_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mark_dirty |=> dirty_q[$past(idx)]);
endmodule

// File: rtl/dcache_data_store.sv
`timescale 1ns/1ps
// dcache_data_store: line data array.
// Provides a combinational word read (for loads) and a beat read (for
// write-back). Writes either one beat of a refill or byte lanes of one
// word. Assumes the controller never requests both writes in one cycle.
module dcache_data_store #(
    parameter int NUM_LINES = 512,
    parameter int IDX_W     = 9,
    parameter int LINE_W    = 256,
    parameter int BEAT_W    = 128,
    parameter int WORD_W    = 32,
    parameter int WSEL_W    = 3,
    parameter int CNT_W     = 1,
    localparam int LANES    = WORD_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WSEL_W-1:0] word_sel,
    input  logic [CNT_W-1:0]  beat_sel,
    output logic [WORD_W-1:0] rd_word,
    output logic [BEAT_W-1:0] rd_beat,
    input  logic [LANES-1:0]  word_we,
    input  logic [WORD_W-1:0] word_wdata,
    input  logic              beat_we,
    input  logic [BEAT_W-1:0] beat_wdata
);
    logic [LINE_W-1:0] line_q [NUM_LINES];

    // Word and beat selection from the addressed line.
    always_comb begin
        rd_word = line_q[idx][word_sel*WORD_W +: WORD_W];
        rd_beat = line_q[idx][beat_sel*BEAT_W +: BEAT_W];
    end

    // Refill beat write or byte-lane store merge.
    always_ff @(posedge clk) begin
        if (beat_we) begin
            line_q[idx][beat_sel*BEAT_W +: BEAT_W] <= beat_wdata;
        end else begin
            for (int b = 0; b < LANES; b++) begin
                if (word_we[b]) line_q[idx][word_sel*WORD_W + b*8 +: 8] <= word_wdata[b*8 +: 8];
            end
        end
    end

    assert_single_writer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        beat_we |-> (word_we == '0));
endmodule

// File: rtl/dcache_ctrl.sv
`timescale 1ns/1ps
// dcache_ctrl: miss-handling state machine.
// Idle serves hits. A miss with a dirty victim goes through write command,
// write beats, read command and read beats; a clean miss skips the first
// two. It returns to idle, where the access completes as a hit.
// Assumes the CPU holds its request stable while stall is high.
module dcache_ctrl
    import dcache_pkg::*;
#(
    parameter int BEATS = 2,
    parameter int CNT_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             access,
    input  logic             hit,
    input  logic             victim_dirty,
    input  logic             cmd_full,
    input  logic             wbuf_full,
    input  logic             rbuf_valid,
    output logic             stall,
    output logic             idle,
    output logic             cmd_push,
    output logic [CMD_W-1:0] cmd_code,
    output logic             use_victim,
    output logic             wbuf_push,
    output logic [CNT_W-1:0] beat_sel,
    output logic             rbuf_pop,
    output logic             beat_we,
    output logic             fill_we
);
    dc_state_e        state_q, state_d;
    logic [CNT_W-1:0] beat_q;
    logic             last_beat;

    assign last_beat = (beat_q == CNT_W'(BEATS - 1));
    assign beat_sel  = beat_q;

    // Next state and per-state outputs.
    always_comb begin
        state_d    = state_q;
        stall      = 1'b1;
        idle       = 1'b0;
        cmd_push   = 1'b0;
        cmd_code   = CMD_READ;
        use_victim = 1'b0;
        wbuf_push  = 1'b0;
        rbuf_pop   = 1'b0;
        beat_we    = 1'b0;
        fill_we    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                idle  = 1'b1;
                stall = access && !hit;
                if (access && !hit) state_d = victim_dirty ? ST_WB_CMD : ST_RD_CMD;
            end
            ST_WB_CMD: begin
                use_victim = 1'b1;
                cmd_code   = CMD_WRITE;
                cmd_push   = !cmd_full;
                if (!cmd_full) state_d = ST_WB_DATA;
            end
            ST_WB_DATA: begin
                wbuf_push = !wbuf_full;
                if (!wbuf_full && last_beat) state_d = ST_RD_CMD;
            end
            ST_RD_CMD: begin
                cmd_push = !cmd_full;
                if (!cmd_full) state_d = ST_RD_DATA;
            end
            ST_RD_DATA: begin
                rbuf_pop = 1'b1;
                if (rbuf_valid) begin
                    beat_we = 1'b1;
                    if (last_beat) begin
                        fill_we = 1'b1;
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Beat counter shared by write-back and refill.
    always_ff @(posedge clk) begin
        if (!rst_n) beat_q <= '0;
        else if (wbuf_push || beat_we) beat_q <= last_beat ? '0 : beat_q + 1'b1;
    end

    assert_pop_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_push && cmd_code == CMD_READ) |=> rbuf_pop);
    assert_beats_follow_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_push && cmd_code == CMD_WRITE) |=> !cmd_push);
endmodule

// File: rtl/wb_dcache.sv
`timescale 1ns/1ps
// wb_dcache: direct-mapped write-back, write-allocate data cache.
// Hits complete combinationally; misses stall, optionally write back the
// dirty victim, then refill through FIFO-style DRAM queues.
// Assumes at least two beats per line and a stable CPU request during stall.
module wb_dcache
    import dcache_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int NUM_LINES   = 512,
    parameter int LINE_BYTES  = 32,
    parameter int BEAT_W      = 128,
    parameter int DRAM_WORD_W = 64,
    parameter int DRAM_ADDR_W = 31
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      cpu_addr,
    input  logic [WORD_W-1:0]      cpu_wdata,
    input  logic [WORD_W/8-1:0]    cpu_wstrb,
    input  logic                   cpu_rd,
    output logic                   cpu_stall,
    output logic [WORD_W-1:0]      cpu_rdata,
    input  logic                   mem_cmd_full,
    output logic                   mem_cmd_push,
    output logic [CMD_W-1:0]       mem_cmd_code,
    output logic [DRAM_ADDR_W-1:0] mem_cmd_addr,
    input  logic                   wbuf_full,
    output logic                   wbuf_push,
    output logic [BEAT_W-1:0]      wbuf_data,
    output logic [BEAT_W/8-1:0]    wbuf_mask_n,
    input  logic                   rbuf_valid,
    input  logic [BEAT_W-1:0]      rbuf_data,
    output logic                   rbuf_pop
);
    localparam int LINE_W = LINE_BYTES * 8;
    localparam int BEATS  = LINE_W / BEAT_W;
    localparam int CNT_W  = $clog2(BEATS);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int IDX_W  = $clog2(NUM_LINES);
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int LB_W   = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFF_W - LB_W;
    localparam int LOW_Z  = OFF_W - $clog2(DRAM_WORD_W / 8);
    localparam int PAD_W  = DRAM_ADDR_W - (ADDR_W - OFF_W) - LOW_Z;

    logic [TAG_W-1:0]  cpu_tag, line_tag, cmd_tag;
    logic [IDX_W-1:0]  cpu_idx;
    logic [WSEL_W-1:0] cpu_wsel;
    logic              line_valid, line_dirty, hit, access;
    logic              idle, use_victim, beat_we, fill_we;
    logic [CNT_W-1:0]  beat_sel;
    logic              unused_byte_bits;

    // Address field split and hit detection.
    always_comb begin
        cpu_tag  = cpu_addr[ADDR_W-1 -: TAG_W];
        cpu_idx  = cpu_addr[OFF_W +: IDX_W];
        cpu_wsel = cpu_addr[LB_W +: WSEL_W];
        access   = cpu_rd || (cpu_wstrb != '0);
        hit      = line_valid && (line_tag == cpu_tag);
        cmd_tag  = use_victim ? line_tag : cpu_tag;
    end

    assign unused_byte_bits = ^cpu_addr[LB_W-1:0];
    assign mem_cmd_addr     = {{PAD_W{1'b0}}, cmd_tag, cpu_idx, {LOW_Z{1'b0}}};
    assign wbuf_mask_n      = '0;

    dcache_tag_store #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) tags_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (cpu_idx),
        .tag_out   (line_tag),
        .valid_out (line_valid),
        .dirty_out (line_dirty),
        .fill_we   (fill_we),
        .fill_tag  (cpu_tag),
        .mark_dirty(idle && hit && (cpu_wstrb != '0))
    );

    dcache_data_store #(
        .NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .LINE_W(LINE_W), .BEAT_W(BEAT_W),
        .WORD_W(WORD_W), .WSEL_W(WSEL_W), .CNT_W(CNT_W)
    ) data_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (cpu_idx),
        .word_sel  (cpu_wsel),
        .beat_sel  (beat_sel),
        .rd_word   (cpu_rdata),
        .rd_beat   (wbuf_data),
        .word_we   ((idle && hit) ? cpu_wstrb : '0),
        .word_wdata(cpu_wdata),
        .beat_we   (beat_we),
        .beat_wdata(rbuf_data)
    );

    dcache_ctrl #(
        .BEATS(BEATS), .CNT_W(CNT_W)
    ) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .access      (access),
        .hit         (hit),
        .victim_dirty(line_valid && line_dirty),
        .cmd_full    (mem_cmd_full),
        .wbuf_full   (wbuf_full),
        .rbuf_valid  (rbuf_valid),
        .stall       (cpu_stall),
        .idle        (idle),
        .cmd_push    (mem_cmd_push),
        .cmd_code    (mem_cmd_code),
        .use_victim  (use_victim),
        .wbuf_push   (wbuf_push),
        .beat_sel    (beat_sel),
        .rbuf_pop    (rbuf_pop),
        .beat_we     (beat_we),
        .fill_we     (fill_we)
    );

    assert_hit_no_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (access && hit) |-> !cpu_stall);
    assert_fill_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_we |=> (hit && !line_dirty));
endmodule

// File: tb/wb_dcache_tb_top.sv
`timescale 1ns/1ps
// Bench for wb_dcache: a behavioural DRAM behind the three queues, a
// vector table walked by one loop, then directed backpressure and reset tests.
module wb_dcache_tb_top;
    localparam int LAT = 3;
    localparam int NV  = 14;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [31:0]  cpu_addr, cpu_wdata, cpu_rdata;
    logic [3:0]   cpu_wstrb;
    logic         cpu_rd, cpu_stall;
    logic         mem_cmd_full, mem_cmd_push;
    logic [2:0]   mem_cmd_code;
    logic [30:0]  mem_cmd_addr;
    logic         wbuf_full, wbuf_push;
    logic [127:0] wbuf_data, rbuf_data;
    logic [15:0]  wbuf_mask_n;
    logic         rbuf_valid, rbuf_pop;

    always #10 clk = ~clk;

    wb_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_wstrb(cpu_wstrb), .cpu_rd(cpu_rd), .cpu_stall(cpu_stall),
        .cpu_rdata(cpu_rdata), .mem_cmd_full(mem_cmd_full), .mem_cmd_push(mem_cmd_push),
        .mem_cmd_code(mem_cmd_code), .mem_cmd_addr(mem_cmd_addr), .wbuf_full(wbuf_full),
        .wbuf_push(wbuf_push), .wbuf_data(wbuf_data), .wbuf_mask_n(wbuf_mask_n),
        .rbuf_valid(rbuf_valid), .rbuf_data(rbuf_data), .rbuf_pop(rbuf_pop)
    );

    typedef struct packed {
        logic        wr;
        logic [3:0]  strb;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [1:0]  exp_rd;
        logic [1:0]  exp_wr;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'h0, 32'h0000_0040, 32'h0,          2'd1, 2'd0}, // compulsory miss
        '{1'b0, 4'h0, 32'h0000_0044, 32'h0,          2'd0, 2'd0}, // load hit
        '{1'b1, 4'hF, 32'h0000_0048, 32'h1122_3344,  2'd0, 2'd0}, // full store hit
        '{1'b1, 4'h5, 32'h0000_004C, 32'hAABB_CCDD,  2'd0, 2'd0}, // partial store hit
        '{1'b0, 4'h0, 32'h0000_004C, 32'h0,          2'd0, 2'd0}, // merged readback
        '{1'b0, 4'h0, 32'h0000_4040, 32'h0,          2'd1, 2'd1}, // conflict, dirty victim
        '{1'b0, 4'h0, 32'h0000_0048, 32'h0,          2'd1, 2'd0}, // back, clean victim
        '{1'b0, 4'h0, 32'h0000_004C, 32'h0,          2'd0, 2'd0}, // hit after round trip
        '{1'b1, 4'h2, 32'h0001_0060, 32'h0000_EE00,  2'd1, 2'd0}, // store miss allocate
        '{1'b0, 4'h0, 32'h0001_0060, 32'h0,          2'd0, 2'd0}, // merged word
        '{1'b1, 4'h8, 32'h0002_0060, 32'h9900_0000,  2'd1, 2'd1}, // store miss, dirty victim
        '{1'b0, 4'h0, 32'h0001_0064, 32'h0,          2'd1, 2'd1}, // load miss, dirty victim
        '{1'b0, 4'h0, 32'h0001_0060, 32'h0,          2'd0, 2'd0}, // hit after write-back
        '{1'b0, 4'h0, 32'h0002_0060, 32'h0,          2'd1, 2'd0}  // reload stored byte
    };

    int checks = 0, fails = 0;
    int cycle = 0, rd_cmds = 0, wr_cmds = 0;
    int push_viol = 0, bad_code = 0, mask_bad = 0;
    int rd_ready = 0, rd_beat = 0, wb_beat = 0;
    bit done = 1'b0;
    logic [30:0]  last_rd_addr = '0;
    logic [30:0]  rd_q [$];
    logic [30:0]  wr_q [$];
    logic [255:0] wb_buf = '0;
    logic [255:0] dram [logic [30:0]];
    logic [31:0]  gold [logic [31:0]];

    function automatic logic [31:0] init_word(input logic [31:0] a);
        return a ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [255:0] dram_line(input logic [30:0] da);
        logic [255:0] l;
        if (dram.exists(da)) return dram[da];
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = init_word({da[28:0], 3'b000} + 32'(4 * w));
        return l;
    endfunction

    function automatic logic [31:0] gold_get(input logic [31:0] a);
        logic [31:0] k = {a[31:2], 2'b00};
        return gold.exists(k) ? gold[k] : init_word(k);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // DRAM model: drives read beats after each falling edge, takes pushes late in the cycle.
    initial begin
        logic [255:0] line;
        rbuf_valid = 1'b0;
        rbuf_data  = '0;
        forever begin
            @(negedge clk);
            cycle++;
            if (rd_q.size() > 0 && cycle >= rd_ready) begin
                line       = dram_line(rd_q[0]);
                rbuf_valid = 1'b1;
                rbuf_data  = line[rd_beat*128 +: 128];
            end else begin
                rbuf_valid = 1'b0;
            end
            #8;
            if (rst_n && mem_cmd_push) begin
                if (mem_cmd_full) push_viol++;
                else if (mem_cmd_code == 3'b001) begin
                    rd_q.push_back(mem_cmd_addr);
                    if (rd_q.size() == 1) rd_ready = cycle + LAT;
                    rd_cmds++;
                    last_rd_addr = mem_cmd_addr;
                end else if (mem_cmd_code == 3'b000) begin
                    wr_q.push_back(mem_cmd_addr);
                    wr_cmds++;
                end else bad_code++;
            end
            if (rst_n && wbuf_push) begin
                if (wbuf_full) push_viol++;
                else begin
                    if (wbuf_mask_n != 16'h0) mask_bad++;
                    wb_buf[wb_beat*128 +: 128] = wbuf_data;
                    wb_beat++;
                    if (wb_beat == 2) begin
                        dram[wr_q.pop_front()] = wb_buf;
                        wb_beat = 0;
                    end
                end
            end
            if (rbuf_valid && rbuf_pop) begin
                rd_beat++;
                if (rd_beat == 2) begin
                    void'(rd_q.pop_front());
                    rd_beat  = 0;
                    rd_ready = cycle + LAT;
                end
            end
        end
    end

    task automatic run_op(input bit wr, input logic [3:0] strb, input logic [31:0] addr,
                          input logic [31:0] wdata, output logic [31:0] rdata, output int stalls);
        @(negedge clk);
        cpu_addr  = addr;
        cpu_wdata = wdata;
        cpu_wstrb = wr ? strb : 4'h0;
        cpu_rd    = !wr;
        stalls    = 0;
        forever begin
            #8;
            if (!cpu_stall) break;
            stalls++;
            @(negedge clk);
        end
        rdata = cpu_rdata;
        @(negedge clk);
        cpu_rd    = 1'b0;
        cpu_wstrb = 4'h0;
    endtask

    task automatic gold_store(input logic [3:0] strb, input logic [31:0] addr, input logic [31:0] wdata);
        logic [31:0] w = gold_get(addr);
        for (int b = 0; b < 4; b++) if (strb[b]) w[b*8 +: 8] = wdata[b*8 +: 8];
        gold[{addr[31:2], 2'b00}] = w;
    endtask

    task automatic idle_outputs_check(input string tag);
        #8;
        check(!cpu_stall && !mem_cmd_push && !wbuf_push && !rbuf_pop, tag,
              {28'h0, cpu_stall, mem_cmd_push, wbuf_push, rbuf_pop}, 32'h0);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        logic [31:0] rdata;
        int stalls, rd0, wr0;
        rst_n = 1'b0;
        cpu_addr = '0; cpu_wdata = '0; cpu_wstrb = '0; cpu_rd = 1'b0;
        mem_cmd_full = 1'b0; wbuf_full = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle_outputs_check("R2 idle outputs after reset");

        // Vector table: R1 mapping, R4 address, R5/R10 write-back, R6 refill, R7/R8/R9 access.
        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VECS[i];
            rd0 = rd_cmds;
            wr0 = wr_cmds;
            run_op(v.wr, v.strb, v.addr, v.wdata, rdata, stalls);
            if (v.wr) gold_store(v.strb, v.addr, v.wdata);
            else check(rdata == gold_get(v.addr), v.exp_rd != 0 ? "R6 refill data" : "R7 hit data",
                       rdata, gold_get(v.addr));
            check(rd_cmds - rd0 == int'(v.exp_rd), "R1 read commands", 32'(rd_cmds - rd0), 32'(v.exp_rd));
            check(wr_cmds - wr0 == int'(v.exp_wr), v.exp_wr != 0 ? "R5 write-back count" : "R10 clean miss no write",
                  32'(wr_cmds - wr0), 32'(v.exp_wr));
            check((stalls == 0) == (v.exp_rd == 0), v.exp_rd != 0 ? "R9 stall on miss" : "R8 no stall on hit",
                  32'(stalls), 32'(v.exp_rd));
            if (v.exp_rd != 0)
                check(last_rd_addr == {2'b00, v.addr[31:5], 2'b00}, "R4 DRAM address",
                      {1'b0, last_rd_addr}, {3'b000, v.addr[31:5], 2'b00});
        end

        // R11: command queue full holds off the refill read.
        mem_cmd_full = 1'b1;
        rd0 = rd_cmds;
        fork
            run_op(1'b0, 4'h0, 32'h0000_3FE0, 32'h0, rdata, stalls);
            begin repeat (6) @(negedge clk); mem_cmd_full = 1'b0; end
        join
        check(rdata == gold_get(32'h3FE0), "R11 data after command backpressure", rdata, gold_get(32'h3FE0));
        check(stalls >= 6, "R11 stall covers full period", 32'(stalls), 32'd6);
        check(rd_cmds - rd0 == 1, "R11 one read command", 32'(rd_cmds - rd0), 32'd1);

        // R11: write-data queue full holds off the victim beats.
        run_op(1'b1, 4'h3, 32'h0000_3FE4, 32'h0000_7788, rdata, stalls);
        gold_store(4'h3, 32'h3FE4, 32'h0000_7788);
        wbuf_full = 1'b1;
        rd0 = rd_cmds;
        wr0 = wr_cmds;
        fork
            run_op(1'b0, 4'h0, 32'h0000_7FE0, 32'h0, rdata, stalls);
            begin repeat (5) @(negedge clk); wbuf_full = 1'b0; end
        join
        check(rdata == gold_get(32'h7FE0), "R11 data after write backpressure", rdata, gold_get(32'h7FE0));
        check(wr_cmds - wr0 == 1 && rd_cmds - rd0 == 1, "R5 dirty miss commands",
              32'((wr_cmds - wr0) * 16 + (rd_cmds - rd0)), 32'h11);
        run_op(1'b0, 4'h0, 32'h0000_3FE4, 32'h0, rdata, stalls);
        check(rdata == gold_get(32'h3FE4), "R5 store survives write-back", rdata, gold_get(32'h3FE4));

        check(push_viol == 0, "R11 no push while full", 32'(push_viol), 32'd0);
        check(bad_code == 0, "R3 command codes", 32'(bad_code), 32'd0);
        check(mask_bad == 0, "R5 write mask all enabled", 32'(mask_bad), 32'd0);

        // R2: reset invalidates resident lines.
        apply_reset();
        idle_outputs_check("R2 idle outputs after second reset");
        rd0 = rd_cmds;
        run_op(1'b0, 4'h0, 32'h0000_0044, 32'h0, rdata, stalls);
        check(rd_cmds - rd0 == 1, "R2 first access misses", 32'(rd_cmds - rd0), 32'd1);
        check(rdata == gold_get(32'h44), "R2 data after reset", rdata, gold_get(32'h44));

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule